// File: doc/BRIEF.md
# Per-PE Weight-Streamed MAC Array

This block is a grid of multiply-accumulate processing elements built for dense layers in which every weight is used exactly once per input sample. Each PE has its own weight input, so the whole grid can take a new set of weights on every clock edge. One signed activation per row is broadcast to every PE in that row. Each column adds the products of its PEs and delivers the sum on a registered output, together with a valid flag.

Because no weight passes from one PE to the next, a single layer with no weight reuse still keeps every PE busy on every cycle. Convolution layers run on the same array through a second mode. In that mode the PEs keep a weight set that was loaded earlier and apply it to a stream of activations. New weights are written into the held registers only in cycles that carry a weight-valid strobe.

Top module: `wsmac_array`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `col_vld` and every column sum clears to 0 after that edge, and every PE's held weight clears to 0. A hold-mode computation that follows reset without a weight load therefore yields sums of 0.
- R2: In stream mode (`mode_hold`=0), take any edge where `w_vld`=1 and at least one `a_vld` bit is 1. After it, every column c outputs the signed sum over rows r of w(r,c)*a(r). Here w(r,c) is `w_data[(r*COLS+c)*WW +: WW]`, a(r) is `a_data[r*AW +: AW]`, and the sum sits in `col_sum[c*SW +: SW]`. All `col_vld` bits are 1 after that same edge.
- R3: In stream mode, a different weight set presented on each of several back-to-back cycles yields one correct set of sums per cycle, with no gap cycles.
- R4: A row whose `a_vld` bit is 0 adds nothing to any column sum in either mode, whatever its activation and weights hold.
- R5: In stream mode, an edge with `w_vld`=0 is a stall. After it, `col_vld` is 0 and every column sum keeps its previous value.
- R6: An edge where all `a_vld` bits are 0 produces no result in either mode. After it, `col_vld` is 0 and the sums keep their values.
- R7: In hold mode (`mode_hold`=1), products use each PE's held weight and `w_data` is ignored. An edge with `w_vld`=1 copies `w_data` into the held weights. In both modes the copy is used from the next edge on, so a computation in the loading cycle still uses the old held weights.
- R8: In hold mode, an edge where any `a_vld` bit is 1 produces a result whatever the value of `w_vld`.
- R9: Products and sums are signed two's complement at full width (SW = AW+WW+log2(ROWS)), so they never overflow. At the extremes, eight products of -128*-128 sum to 131072.
- R10: All `col_vld` bits are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hold | input | 1 | 0: stream fresh weights, 1: use held weights |
| w_vld | input | 1 | Weight strobe; stall when low in stream mode, load when high |
| w_data | input | ROWS*COLS*WW | Per-PE signed weights, PE (r,c) at slice r*COLS+c |
| a_vld | input | ROWS | Per-row activation valid |
| a_data | input | ROWS*AW | Per-row signed activations |
| col_vld | output | COLS | Registered per-column result valid |
| col_sum | output | COLS*SW | Registered per-column signed sums |

## Verification
The bench builds the array with its defaults: an 8 by 8 grid with 8-bit weights and activations, which gives 19-bit column sums. With a full eight-row grid, extreme operands really reach the carries of the top sum bits, and a one-row enable pattern separates each row's contribution. Random phases mix the two modes, weight strobes and row masks. This exercises held-weight loads against streamed cycles and stalls mixed with real results.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_HOLD   = 1'b1
  } wsmac_mode_e;

  // Width of a column sum that cannot overflow for the given operand sizes.
  function automatic int sum_width(input int aw, input int ww, input int rows);
    return aw + ww + ((rows > 1) ? $clog2(rows) : 0);
  endfunction

endpackage

// File: rtl/wsmac_pe.sv
module wsmac_pe #(
  parameter int AW = 8,
  parameter int WW = 8,
  localparam int PW = AW + WW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          use_held,
  input  logic          row_en,
  input  logic [WW-1:0] w_in,
  input  logic [AW-1:0] a_in,
  output logic [PW-1:0] prod
);

  logic signed [WW-1:0] held_w;
  logic signed [WW-1:0] w_eff;

  always_ff @(posedge clk) begin
    if (rst)       held_w <= '0;
    else if (load) held_w <= w_in;
  end

  always_comb begin
    w_eff = use_held ? held_w : $signed(w_in);
    if (row_en) prod = $signed(a_in) * w_eff;
    else        prod = '0;
  end

endmodule

// File: rtl/wsmac_col_sum.sv
module wsmac_col_sum #(
  parameter int ROWS = 8,
  parameter int PW   = 16,
  parameter int SW   = 19
) (
  input  logic [ROWS*PW-1:0] prods,
  output logic [SW-1:0]      sum
);

  logic signed [SW-1:0] ext [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_ext
    assign ext[r] = SW'($signed(prods[r*PW +: PW]));
  end

  always_comb begin
    sum = '0;
    for (int r = 0; r < ROWS; r++) sum = sum + ext[r];
  end

endmodule

// File: rtl/wsmac_array.sv
module wsmac_array
  import wsmac_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int AW   = 8,
  parameter int WW   = 8,
  localparam int PW  = AW + WW,
  localparam int SW  = sum_width(AW, WW, ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_hold,
  input  logic                 w_vld,
  input  logic [ROWS*COLS*WW-1:0] w_data,
  input  logic [ROWS-1:0]      a_vld,
  input  logic [ROWS*AW-1:0]   a_data,
  output logic [COLS-1:0]      col_vld,
  output logic [COLS*SW-1:0]   col_sum
);

  wsmac_mode_e mode;
  logic        fire;

  assign mode = wsmac_mode_e'(mode_hold);

  always_comb begin
    unique case (mode)
      MODE_STREAM: fire = w_vld && (|a_vld);
      MODE_HOLD:   fire = |a_vld;
      default:     fire = 1'b0;
    endcase
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS*PW-1:0] prods;
    logic [SW-1:0]      sum_d;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      wsmac_pe #(.AW(AW), .WW(WW)) u_pe (
        .clk      (clk),
        .rst      (rst),
        .load     (w_vld),
        .use_held (mode == MODE_HOLD),
        .row_en   (a_vld[r]),
        .w_in     (w_data[(r*COLS+c)*WW +: WW]),
        .a_in     (a_data[r*AW +: AW]),
        .prod     (prods[r*PW +: PW])
      );
    end

    wsmac_col_sum #(.ROWS(ROWS), .PW(PW), .SW(SW)) u_sum (
      .prods (prods),
      .sum   (sum_d)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        col_vld[c]          <= 1'b0;
        col_sum[c*SW +: SW] <= '0;
      end else begin
        col_vld[c] <= fire;
        if (fire) col_sum[c*SW +: SW] <= sum_d;
      end
    end
  end

endmodule

// File: rtl/wsmac_array_chk.sv
module wsmac_array_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int AW   = 8,
  parameter int WW   = 8,
  localparam int SW  = wsmac_pkg::sum_width(AW, WW, ROWS)
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_hold,
  input logic               w_vld,
  input logic [ROWS-1:0]    a_vld,
  input logic [COLS-1:0]    col_vld,
  input logic [COLS*SW-1:0] col_sum
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (col_vld == '0) && (col_sum == '0));

  // R2
  a_r2_stream_result: assert property (@(posedge clk) disable iff (rst)
    (!mode_hold && w_vld && (|a_vld)) |=> (&col_vld));

  // R5
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (!mode_hold && !w_vld) |=> (col_vld == '0) && $stable(col_sum));

  // R6
  a_r6_no_rows_idle: assert property (@(posedge clk) disable iff (rst)
    (a_vld == '0) |=> (col_vld == '0) && $stable(col_sum));

  // R8
  a_r8_hold_fires: assert property (@(posedge clk) disable iff (rst)
    (mode_hold && (|a_vld)) |=> (&col_vld));

  // R10
  a_r10_cols_agree: assert property (@(posedge clk) disable iff (rst)
    ($countones(col_vld) == 0) || ($countones(col_vld) == COLS));

endmodule

bind wsmac_array wsmac_array_chk #(
  .ROWS(ROWS), .COLS(COLS), .AW(AW), .WW(WW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_hold (mode_hold),
  .w_vld     (w_vld),
  .a_vld     (a_vld),
  .col_vld   (col_vld),
  .col_sum   (col_sum)
);

// File: tb/wsmac_array_tb.sv
`timescale 1ns/1ps
module wsmac_array_tb;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int AW   = 8;
  localparam int WW   = 8;
  localparam int SW   = AW + WW + $clog2(ROWS);

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    mode_hold;
  logic                    w_vld;
  logic [ROWS*COLS*WW-1:0] w_data;
  logic [ROWS-1:0]         a_vld;
  logic [ROWS*AW-1:0]      a_data;
  logic [COLS-1:0]         col_vld;
  logic [COLS*SW-1:0]      col_sum;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic signed [WW-1:0] wb   [ROWS][COLS];
  logic signed [WW-1:0] held [ROWS][COLS];
  logic signed [AW-1:0] ab   [ROWS];
  int  exp_sum [COLS];
  bit  exp_vld;

  always #5 clk = ~clk;

  wsmac_array #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .WW(WW)) u_dut (
    .clk(clk), .rst(rst), .mode_hold(mode_hold), .w_vld(w_vld),
    .w_data(w_data), .a_vld(a_vld), .a_data(a_data),
    .col_vld(col_vld), .col_sum(col_sum)
  );

  function automatic int col_model(input int c, input bit m, input logic [ROWS-1:0] av);
    int s = 0;
    for (int r = 0; r < ROWS; r++)
      if (av[r]) s += int'(ab[r]) * int'(m ? held[r][c] : wb[r][c]);
    return s;
  endfunction

  task automatic check_outputs(input string tag);
    for (int c = 0; c < COLS; c++) begin
      int got = int'($signed(col_sum[c*SW +: SW]));
      checks++;
      if (got != exp_sum[c]) begin
        errors++;
        $display("FAIL %s col %0d sum actual %0d expected %0d", tag, c, got, exp_sum[c]);
      end
    end
    checks++;
    if (col_vld != {COLS{exp_vld}}) begin
      errors++;
      $display("FAIL %s col_vld actual %b expected %b", tag, col_vld, {COLS{exp_vld}});
    end
  endtask

  task automatic step(input string tag, input bit m, input bit wv, input logic [ROWS-1:0] av);
    bit fire;
    @(negedge clk);
    mode_hold = m;
    w_vld     = wv;
    a_vld     = av;
    for (int r = 0; r < ROWS; r++) begin
      a_data[r*AW +: AW] = ab[r];
      for (int c = 0; c < COLS; c++) w_data[(r*COLS+c)*WW +: WW] = wb[r][c];
    end
    fire = m ? (av != '0) : (wv && av != '0);
    if (fire)
      for (int c = 0; c < COLS; c++) exp_sum[c] = col_model(c, m, av);
    exp_vld = fire;
    if (wv)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) held[r][c] = wb[r][c];
    @(posedge clk);
    #1;
    check_outputs(tag);
  endtask

  task automatic rand_operands();
    for (int r = 0; r < ROWS; r++) begin
      ab[r] = AW'($urandom);
      for (int c = 0; c < COLS; c++) wb[r][c] = WW'($urandom);
    end
  endtask

  task automatic fill_operands(input int wv, input int av);
    for (int r = 0; r < ROWS; r++) begin
      ab[r] = AW'(av);
      for (int c = 0; c < COLS; c++) wb[r][c] = WW'(wv);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; mode_hold = 1'b0; w_vld = 1'b0; a_vld = '0;
    w_data = '0; a_data = '0;
    for (int r = 0; r < ROWS; r++) begin
      ab[r] = '0;
      for (int c = 0; c < COLS; c++) begin wb[r][c] = '0; held[r][c] = '0; end
    end
    for (int c = 0; c < COLS; c++) exp_sum[c] = 0;
    exp_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_outputs("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // R1 / R7: held weights are zero after reset; w_data ignored in hold mode
    rand_operands();
    step("R1 held zero", 1'b1, 1'b0, '1);

    // R2 / R3: back-to-back streamed weight sets
    for (int i = 0; i < 30; i++) begin
      rand_operands();
      step("R2 R3 stream", 1'b0, 1'b1, '1);
    end

    // R9: extreme operands
    fill_operands(-128, -128);
    step("R9 max positive", 1'b0, 1'b1, '1);
    fill_operands(-128, 127);
    step("R9 max negative", 1'b0, 1'b1, '1);

    // R4: single active rows
    for (int r = 0; r < ROWS; r++) begin
      rand_operands();
      step("R4 one row", 1'b0, 1'b1, ROWS'(1) << r);
    end

    // R5: stall keeps sums
    rand_operands();
    step("R5 stall", 1'b0, 1'b0, '1);
    rand_operands();
    step("R5 stall again", 1'b0, 1'b0, 8'h5A);

    // R6: no row valid
    rand_operands();
    step("R6 no rows stream", 1'b0, 1'b1, '0);
    rand_operands();
    step("R6 no rows hold", 1'b1, 1'b1, '0);

    // R7 / R8: load then reuse with w_data changing
    rand_operands();
    step("R7 load cycle", 1'b1, 1'b1, '1);
    for (int i = 0; i < 6; i++) begin
      rand_operands();
      step("R7 R8 reuse", 1'b1, 1'b0, ROWS'($urandom));
    end

    // Random mix of everything
    for (int i = 0; i < 400; i++) begin
      rand_operands();
      step("R2 R4 R5 R7 R8 R10 random", 1'($urandom), 1'($urandom), ROWS'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule